// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Claim and Completion

This block collects a set of level-sensitive interrupt lines and distributes them to several interrupt targets, where each target stands for one hart running in one privilege mode. Software gives every source an urgency value and gives every target an enable mask and an urgency floor. The block raises a target's interrupt line whenever an enabled, waiting source for that target is more urgent than the target's floor.

A target reads its claim word to take ownership of the most urgent source that is waiting for it. The read returns the source number, clears that source's waiting flag and hides the source from every target until the owner writes the same number back to the same claim word. Software can also poll the claim word without waiting for the interrupt line. Source numbers start at 1, and the value 0 means that nothing is waiting.

Top module: `pic_top`

## Requirements
- R1: After reset all urgency values, enable masks, floors and waiting flags read back as 0, every interrupt line is low, and a claim read returns 0.
- R2: A source whose line is high on a clock edge, and is neither waiting nor owned, becomes waiting. It stays waiting after the line drops. The waiting word (address 0x40) shows source k in bit k.
- R3: A source with urgency 0 never raises an interrupt line and is never returned by a claim.
- R4: A claim returns the waiting source that is enabled for that target and has the highest urgency. When urgencies are equal, the lower source number wins.
- R5: Each target has its own enable mask (address 0x80+t, bit k for source k). A source that is masked off for a target is never offered to that target.
- R6: Target t's interrupt line is high exactly when its best eligible source has an urgency strictly greater than that target's floor (address 0xC0+2t).
- R7: A claim (read of 0xC1+2t) clears the source's waiting flag. Until completion the source is offered to no target, and its line being high does not make it waiting again.
- R8: A write of the claimed number to the owner's claim word ends the claim. If the line is still high, the source is waiting again one cycle later.
- R9: A completion write from a target that does not own the claim, or naming a source that is not claimed, changes nothing.
- R10: The request ready output is always high. Every read gives exactly one response pulse on the next cycle, and writes give none.
- R11: If a claim read and a new source arrival fall on the same edge, the claim returns the winner from before that edge, and the new source stays waiting.
- R12: A claim read that finds no eligible source returns 0 and changes no state.
- R13: Urgency values live at addresses 1 to N (one word per source number).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_level | input | NUM_SRC | Level-sensitive source lines; bit k-1 is source k |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | NUM_CTX | Interrupt line per target |

## Verification
Two functions can land on the same clock edge: a claim read that removes the current winner, and the first sampling of a more urgent source line. The bench raises source 2 on the exact edge where target 0 reads its claim word while only source 5 is eligible. It then expects 5 as the response, followed by a waiting word that still holds source 2 and a second claim that returns 2. The bench also joins a completion with a line that is still high, and expects the source to be waiting again on the cycle after the completion edge.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_ADDR_W = 8;
    localparam int PIC_IDX_W  = 6;

    typedef enum logic [1:0] {
        RGN_PRIO = 2'd0,
        RGN_PEND = 2'd1,
        RGN_ENAB = 2'd2,
        RGN_CTX  = 2'd3
    } region_e;

    typedef struct packed {
        region_e                rgn;
        logic [PIC_IDX_W-1:0]   idx;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(input logic [PIC_ADDR_W-1:0] a);
        bus_dec_t d;
        d.rgn = region_e'(a[PIC_ADDR_W-1 -: 2]);
        d.idx = a[PIC_IDX_W-1:0];
        return d;
    endfunction

    function automatic int ctx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    localparam int ID_W   = $clog2(NUM_SRC + 1),
    localparam int CTX_W  = ctx_width(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               claim_fire,
    input  logic [ID_W-1:0]    claim_id,
    input  logic [CTX_W-1:0]   claim_ctx,
    input  logic               cmpl_fire,
    input  logic [ID_W-1:0]    cmpl_id,
    input  logic [CTX_W-1:0]   cmpl_ctx,
    output logic [NUM_SRC:0]   pending_o,
    output logic [NUM_SRC:0]   claimed_o
);

    assign pending_o[0] = 1'b0;
    assign claimed_o[0] = 1'b0;

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        logic             pend_q;
        logic             clm_q;
        logic [CTX_W-1:0] own_q;
        logic             take;
        logic             done;

        assign take = claim_fire && (claim_id == ID_W'(s));
        assign done = cmpl_fire && (cmpl_id == ID_W'(s)) && clm_q && (own_q == cmpl_ctx);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q <= 1'b0;
                clm_q  <= 1'b0;
                own_q  <= '0;
            end else if (take) begin
                pend_q <= 1'b0;
                clm_q  <= 1'b1;
                own_q  <= claim_ctx;
            end else begin
                if (done)
                    clm_q <= 1'b0;
                if (src_level[s-1] && !clm_q)
                    pend_q <= 1'b1;
            end
        end

        assign pending_o[s] = pend_q;
        assign claimed_o[s] = clm_q;
    end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:0]             eligible,
    input  logic [NUM_SRC:0][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]              best_id,
    output logic [PRIO_W-1:0]            best_prio
);

    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (eligible[s] && (prio[s] > best_prio)) begin
                best_prio = prio[s];
                best_id   = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int DATA_W  = 32,
    localparam int ID_W   = $clog2(NUM_SRC + 1),
    localparam int CTX_W  = ctx_width(NUM_CTX)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_level,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [PIC_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [NUM_CTX-1:0]    irq
);

    logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:0] enab_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [NUM_SRC:0]              pend_vec;
    logic [NUM_SRC:0]              clm_vec;
    logic [NUM_CTX-1:0][ID_W-1:0]   best_id;
    logic [NUM_CTX-1:0][PRIO_W-1:0] best_prio;

    bus_dec_t               dec;
    logic                   rd_fire, wr_fire;
    logic [PIC_IDX_W-2:0]   ctx_hi;
    logic                   ctx_ok, en_ok, src_ok;
    logic [CTX_W-1:0]       ctx_c, en_c;
    logic [ID_W-1:0]        src_i;
    logic                   claim_fire, cmpl_fire;
    logic [DATA_W-1:0]      rdata_d;

    assign req_ready = 1'b1;
    assign dec       = decode_addr(req_addr);
    assign rd_fire   = req_valid && !req_write;
    assign wr_fire   = req_valid && req_write;
    assign ctx_hi    = dec.idx[PIC_IDX_W-1:1];
    assign ctx_ok    = 32'(ctx_hi) < NUM_CTX;
    assign ctx_c     = ctx_hi[CTX_W-1:0];
    assign en_ok     = 32'(dec.idx) < NUM_CTX;
    assign en_c      = dec.idx[CTX_W-1:0];
    assign src_ok    = (dec.idx != '0) && (32'(dec.idx) <= NUM_SRC);
    assign src_i     = dec.idx[ID_W-1:0];

    assign claim_fire = rd_fire && (dec.rgn == RGN_CTX) && dec.idx[0] && ctx_ok;
    assign cmpl_fire  = wr_fire && (dec.rgn == RGN_CTX) && dec.idx[0] && ctx_ok
                        && ((req_wdata >> ID_W) == '0);

    pic_gateway #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) gw_i (
        .clk        (clk),
        .rst        (rst),
        .src_level  (src_level),
        .claim_fire (claim_fire),
        .claim_id   (best_id[ctx_c]),
        .claim_ctx  (ctx_c),
        .cmpl_fire  (cmpl_fire),
        .cmpl_id    (req_wdata[ID_W-1:0]),
        .cmpl_ctx   (ctx_c),
        .pending_o  (pend_vec),
        .claimed_o  (clm_vec)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        logic [NUM_SRC:0] elig;
        assign elig = pend_vec & ~clm_vec & enab_q[c];

        pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
            .eligible  (elig),
            .prio      (prio_q),
            .best_id   (best_id[c]),
            .best_prio (best_prio[c])
        );

        assign irq[c] = best_prio[c] > thr_q[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            enab_q <= '0;
            thr_q  <= '0;
        end else if (wr_fire) begin
            case (dec.rgn)
                RGN_PRIO: if (src_ok) prio_q[src_i] <= req_wdata[PRIO_W-1:0];
                RGN_ENAB: if (en_ok)  enab_q[en_c]  <= {req_wdata[NUM_SRC:1], 1'b0};
                RGN_CTX:  if (ctx_ok && !dec.idx[0]) thr_q[ctx_c] <= req_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_d = '0;
        case (dec.rgn)
            RGN_PRIO: if (src_ok) rdata_d = DATA_W'(prio_q[src_i]);
            RGN_PEND: rdata_d = DATA_W'(pend_vec);
            RGN_ENAB: if (en_ok) rdata_d = DATA_W'(enab_q[en_c]);
            RGN_CTX: begin
                if (ctx_ok)
                    rdata_d = dec.idx[0] ? DATA_W'(best_id[ctx_c]) : DATA_W'(thr_q[ctx_c]);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire)
                rsp_rdata <= rdata_d;
        end
    end

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_CTX = 2,
    parameter int DATA_W  = 32,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic [7:0]         req_addr,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [NUM_CTX-1:0] irq,
    input logic [NUM_SRC:0]   pending_v,
    input logic [NUM_SRC:0]   claimed_v
);

    logic claim_rsp_q;

    always_ff @(posedge clk) begin
        if (rst)
            claim_rsp_q <= 1'b0;
        else
            claim_rsp_q <= req_valid && !req_write && (req_addr[7:6] == 2'b11)
                           && req_addr[0] && (32'(req_addr[5:1]) < NUM_CTX);
    end

    // R10
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R10
    always_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_ready);

    // R7
    claim_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pending_v & claimed_v) == '0);

    // R7
    claim_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && claim_rsp_q && (rsp_rdata != '0)) |-> claimed_v[rsp_rdata[ID_W-1:0]]);

    // R12
    claim_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && claim_rsp_q) |-> (rsp_rdata <= DATA_W'(NUM_SRC)));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0));

endmodule

bind pic_top pic_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .pending_v (pend_vec),
    .claimed_v (clm_vec)
);

// File: tb/pic_top_tb.sv
module pic_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_level = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_top #(.NUM_SRC(NS), .NUM_CTX(NC)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_level (src_level),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    localparam logic [7:0] A_PEND = 8'h40;
    function automatic logic [7:0] a_prio(input int s); return 8'(s); endfunction
    function automatic logic [7:0] a_en(input int c);   return 8'h80 | 8'(c); endfunction
    function automatic logic [7:0] a_thr(input int c);  return 8'hC0 | 8'(2*c); endfunction
    function automatic logic [7:0] a_clm(input int c);  return 8'hC1 | 8'(2*c); endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected response", rsp_rdata, 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_rdata == e.exp, e.tag, rsp_rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd_with_arrival(input logic [7:0] a, input int s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sb_q.push_back('{exp: exp, tag: tag});
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        src_level[s-1] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic [NC-1:0] exp, input string tag);
        @(negedge clk);
        check(irq == exp, tag, 32'(irq), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R10 reset state
        check(req_ready == 1'b1, "R10 ready high", 32'(req_ready), 32'd1);
        chk_irq(2'b00, "R1 irq low after reset");
        rd(a_clm(0), 0, "R1 claim empty after reset");
        rd(A_PEND, 0, "R1 pending clear after reset");
        rd(a_prio(3), 0, "R1 urgency cleared");
        rd(a_thr(1), 0, "R1 floor cleared");

        // R13 urgency programming
        wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5);
        wr(a_prio(4), 0); wr(a_prio(5), 1);
        wr(a_en(0), 32'h3E); wr(a_en(1), 32'h28);
        rd(a_prio(2), 5, "R13 urgency readback");
        rd(a_en(1), 32'h28, "R5 enable readback");

        // R2 / R3: pulse a zero-urgency source
        @(negedge clk); src_level[3] = 1'b1;
        @(negedge clk); src_level[3] = 1'b0;
        rd(A_PEND, 32'h10, "R2 pending latched after line drop");
        chk_irq(2'b00, "R3 zero urgency raises nothing");
        rd(a_clm(0), 0, "R3 zero urgency never claimed");
        rd(A_PEND, 32'h10, "R12 empty claim has no side effect");

        // R6 floor comparison
        @(negedge clk); src_level[0] = 1'b1;
        chk_irq(2'b01, "R6 R5 irq only for enabled target");
        wr(a_thr(0), 2);
        chk_irq(2'b00, "R6 equal floor masks irq");
        wr(a_thr(0), 1);
        chk_irq(2'b01, "R6 floor below urgency");
        wr(a_thr(0), 0);

        // R4 tie and ordering, R7 hiding
        @(negedge clk); src_level[1] = 1'b1; src_level[2] = 1'b1;
        chk_irq(2'b11, "R6 both targets interrupted");
        rd(a_clm(0), 2, "R4 tie goes to lower id");
        rd(a_clm(0), 3, "R4 next most urgent");
        rd(a_clm(1), 0, "R7 claimed source hidden from other target");
        chk_irq(2'b01, "R7 irq drops for other target");
        rd(a_clm(0), 1, "R4 lowest urgency last");
        rd(A_PEND, 32'h10, "R7 reassertion ignored while claimed");
        chk_irq(2'b00, "R7 no irq while all claimed");

        // R9 mismatched completions
        wr(a_clm(1), 3);
        wr(a_clm(0), 6);
        rd(A_PEND, 32'h10, "R9 bad completion ignored");
        rd(a_clm(1), 0, "R9 claim still held");

        // R8 completion with line still high
        wr(a_clm(0), 3);
        rd(A_PEND, 32'h18, "R8 source waiting again after completion");
        chk_irq(2'b11, "R8 irq back on both targets");
        rd(a_clm(1), 3, "R8 other target claims it");

        src_level[0] = 1'b0; src_level[1] = 1'b0;
        wr(a_clm(0), 2);
        wr(a_clm(0), 1);
        rd(A_PEND, 32'h10, "R8 released low lines stay idle");

        // R11 claim and arrival on the same edge
        @(negedge clk); src_level[4] = 1'b1;
        chk_irq(2'b11, "R6 low urgency source over zero floor");
        rd_with_arrival(a_clm(0), 2, 5, "R11 claim returns prior winner");
        rd(A_PEND, 32'h14, "R11 arrival stays waiting");
        rd(a_clm(0), 2, "R11 arrival claimed next");
        rd(a_clm(1), 0, "R7 both candidates hidden");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R10 every read answered", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule